// File: doc/BRIEF.md
# Indirect PHY Register Bridge

This block sits as a slave on a simple synchronous 16-bit register bus and gives a host access to a bank of internal PHY registers without a dedicated management bus. The host first sets the direction of the access in a control register. It then issues one bus write whose address encodes the target: a one-hot PHY select, a page number and a register number. That write launches the operation.

For a write command, the data carried by the launching write goes into the selected PHY register. For a read command, that data is discarded, and the selected word is copied into a data register that the host reads back afterwards. A busy flag covers the time an operation is in flight, and a sticky error flag records any launch address that cannot be decoded. The PHY register bank holds 5 PHYs × 8 pages × 32 registers of 16 bits, and all of it clears on reset.

Top module: `phy_indirect_bridge`

## Requirements
- R1: After reset, `busy` and `err` are 0, the control register reads 0, the data register reads 0, and every PHY register holds 0.
- R2: A write to address 0x8000 stores bit 0 of the write data as the direction (1 = read, 0 = write). A read of 0x8000 returns that bit in bit 0 and zeros in bits 15:1.
- R3: A launching write is a write while `busy` is low to any address with bit 15 set other than 0x8000 and 0x8002. Bits 4:0 give the register number, bits 8:5 give the page, and bit 9+n set selects PHY n (n = 0..4). When the direction is 0, the write data is stored in the selected register.
- R4: When the direction is 1, a launching write ignores its data, and once the operation ends, a read of 0x8002 returns the selected register.
- R5: After a legal launch, `busy` is high for exactly BUSY_CYCLES clock cycles, starting on the cycle after the launch. The operation takes effect on the edge at which `busy` falls.
- R6: While `busy` is high, a read of 0x8002 returns the value the data register held before the launch.
- R7: A launch address with no PHY-select bit set, with more than one set, or with a page above 7 performs no access and leaves `busy` low. It sets `err`, which then stays at 1 until reset.
- R8: A write to a launch address while `busy` is high is ignored: no PHY register changes and `err` is not set.
- R9: `bus_rdata` is 0 when `bus_rd` is low, and also when the read address is neither 0x8000 nor 0x8002.
- R10: Each (PHY, page, register) combination is a separate storage word. The corner words (PHY 0 page 0 register 0, and PHY 4 page 7 register 31) are reachable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Bus write strobe for one cycle |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 16 | Bus address (register or encoded PHY target) |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data, combinational from the address |
| busy | output | 1 | Operation in flight |
| err | output | 1 | Sticky flag for an undecodable launch address |

## Verification
The bench builds the bridge with the default bank geometry of 5 PHYs, 8 pages and 32 registers, and shortens BUSY_CYCLES to 3. The short busy window lets a data-register read fall inside the window and lets a second launch collide with the first. The bench drives both directions at the corner addresses of the bank and checks that neighbouring pages and PHYs stay separate. It also tries each kind of illegal launch: no select bit, two select bits, and page 8. A behavioural model with its own memory predicts `busy`, `err` and `bus_rdata` on every cycle.

// File: rtl/phy_indirect_bridge.sv
module phy_indirect_bridge #(
  parameter int NUM_PHY     = 5,
  parameter int NUM_PAGE    = 8,
  parameter int DW          = 16,
  parameter int BUSY_CYCLES = 4,
  parameter logic [15:0] CTRL_ADDR = 16'h8000,
  parameter logic [15:0] DATA_ADDR = 16'h8002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [15:0]   bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          err
);
  localparam int NUM_REG  = 32;
  localparam int DEPTH    = NUM_PHY * NUM_PAGE * NUM_REG;
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int CNT_W    = $clog2(BUSY_CYCLES + 1);
  localparam int PHY_LSB  = 9;
  localparam int PAGE_LSB = 5;

  logic [DW-1:0]    mem [DEPTH];
  logic             dir_q, busy_q, err_q, op_rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q, idx_new;
  logic [DW-1:0]    wd_q, data_q;
  int               phy_i;

  wire [NUM_PHY-1:0] sel  = bus_addr[PHY_LSB +: NUM_PHY];
  wire [3:0]         page = bus_addr[PAGE_LSB +: 4];
  wire [4:0]         regn = bus_addr[4:0];
  wire is_ctrl = (bus_addr == CTRL_ADDR);
  wire is_data = (bus_addr == DATA_ADDR);
  wire launch  = bus_wr && bus_addr[15] && !is_ctrl && !is_data && !busy_q;
  wire legal   = $onehot(sel) && (int'(page) < NUM_PAGE);
  wire done    = busy_q && (cnt_q == CNT_W'(1));

  always_comb begin
    phy_i = 0;
    for (int i = 0; i < NUM_PHY; i++)
      if (sel[i]) phy_i = i;
    idx_new = IDX_W'(phy_i * NUM_PAGE * NUM_REG + int'(page) * NUM_REG + int'(regn));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      op_rd_q <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      wd_q    <= '0;
      data_q  <= '0;
    end else begin
      if (bus_wr && is_ctrl) dir_q <= bus_wdata[0];
      if (launch && !legal) err_q <= 1'b1;
      if (launch && legal) begin
        busy_q  <= 1'b1;
        cnt_q   <= CNT_W'(BUSY_CYCLES);
        idx_q   <= idx_new;
        op_rd_q <= dir_q;
        wd_q    <= bus_wdata;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (done) begin
          busy_q <= 1'b0;
          if (op_rd_q) data_q <= mem[idx_q];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (done && !op_rd_q) begin
      mem[idx_q] <= wd_q;
    end
  end

  assign busy = busy_q;
  assign err  = err_q;
  assign bus_rdata = !bus_rd ? '0 :
                     is_ctrl ? DW'(dir_q) :
                     is_data ? data_q : '0;
endmodule

module phy_indirect_bridge_chk #(
  parameter int NUM_PHY     = 5,
  parameter int NUM_PAGE    = 8,
  parameter int DW          = 16,
  parameter int BUSY_CYCLES = 4,
  parameter logic [15:0] CTRL_ADDR = 16'h8000,
  parameter logic [15:0] DATA_ADDR = 16'h8002
) (
  input logic clk,
  input logic rst_n,
  input logic bus_wr,
  input logic bus_rd,
  input logic [15:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic busy,
  input logic err,
  input logic [$clog2(BUSY_CYCLES+1)-1:0] cnt_q,
  input logic [DW-1:0] data_q
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  logic [CNT_W:0] run_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else run_q <= '0;

  wire tgt = bus_wr && bus_addr[15] && bus_addr != CTRL_ADDR && bus_addr != DATA_ADDR && !busy;
  wire ok  = ($countones(bus_addr[9 +: NUM_PHY]) == 1) && (int'(bus_addr[8:5]) < NUM_PAGE);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R7
  AST_BAD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (tgt && !ok) |=> (err && !busy)); // R7
  AST_GOOD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (tgt && ok) |=> busy); // R3
  AST_BUSY_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (run_q == (CNT_W+1)'(BUSY_CYCLES))); // R5
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) !(busy && cnt_q == CNT_W'(1)) |=> $stable(data_q)); // R6
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |-> (bus_rdata == '0)); // R9
endmodule

bind phy_indirect_bridge phy_indirect_bridge_chk #(
  .NUM_PHY(NUM_PHY), .NUM_PAGE(NUM_PAGE), .DW(DW), .BUSY_CYCLES(BUSY_CYCLES),
  .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .busy(busy), .err(err), .cnt_q(cnt_q), .data_q(data_q)
);

// File: tb/test_phy_indirect_bridge.sv
`timescale 1ns/1ps
module test_phy_indirect_bridge;
  localparam int BC = 3;
  localparam logic [15:0] CTRL = 16'h8000;
  localparam logic [15:0] DATA = 16'h8002;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic busy, err;
  int checks = 0, errs = 0;

  always #5 clk = ~clk;

  phy_indirect_bridge #(.BUSY_CYCLES(BC)) i_phy_indirect_bridge (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .err(err));

  // behavioural reference model
  int m_mem [1280];
  bit m_dir = 0, m_err = 0, m_oprd = 0, mon_on = 0;
  int m_left = 0, m_idx = 0;
  logic [15:0] m_wd = 0, m_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[k]) m_mem[k] = 0;
      m_dir = 0; m_err = 0; m_left = 0; m_data = 0;
    end else begin
      bit was;
      was = (m_left > 0);
      if (was) begin
        m_left--;
        if (m_left == 0) begin
          if (m_oprd) m_data = 16'(m_mem[m_idx]);
          else m_mem[m_idx] = int'(m_wd);
        end
      end
      if (bus_wr) begin
        if (bus_addr == CTRL) m_dir = bus_wdata[0];
        else if (bus_addr[15] && bus_addr != DATA && !was) begin
          int n, phy;
          n = 0; phy = 0;
          for (int p = 0; p < 5; p++) if (bus_addr[9+p]) begin n++; phy = p; end
          if (n == 1 && bus_addr[8:5] < 8) begin
            m_idx = phy*256 + int'(bus_addr[8:5])*32 + int'(bus_addr[4:0]);
            m_oprd = m_dir; m_wd = bus_wdata; m_left = BC;
          end else m_err = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      logic [15:0] exp_rd;
      exp_rd = !bus_rd ? 16'h0 : (bus_addr == CTRL) ? {15'b0, m_dir} :
               (bus_addr == DATA) ? m_data : 16'h0;
      checks += 3;
      if (busy !== (m_left > 0)) begin errs++; $display("FAIL R5 busy got %0b exp %0b", busy, m_left > 0); end
      if (err !== m_err) begin errs++; $display("FAIL R7 err got %0b exp %0b", err, m_err); end
      if (bus_rdata !== exp_rd) begin errs++; $display("FAIL R9 rdata got %h exp %h", bus_rdata, exp_rd); end
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin errs++; $display("FAIL %s got %h exp %h", tag, got, exp); end
  endtask

  task automatic bus_write(logic [15:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(logic [15:0] a, string tag, logic [15:0] exp);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_idle();
    #1; while (busy === 1'b1) begin @(negedge clk); #1; end
  endtask

  function automatic logic [15:0] tadr(int phy, int page, int r);
    return 16'h8000 | 16'(1 << (9 + phy)) | 16'(page << 5) | 16'(r);
  endfunction

  task automatic phy_wr(int phy, int page, int r, logic [15:0] v);
    bus_write(CTRL, 16'h0); bus_write(tadr(phy, page, r), v); wait_idle();
  endtask

  task automatic phy_rd(int phy, int page, int r, string tag, logic [15:0] exp);
    bus_write(CTRL, 16'h1); bus_write(tadr(phy, page, r), 16'hDEAD); wait_idle();
    bus_read(DATA, tag, exp);
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL R5 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1; mon_on = 1;
    #1;
    chk("R1 busy after reset", {15'b0, busy}, 16'h0);
    chk("R1 err after reset", {15'b0, err}, 16'h0);
    bus_read(CTRL, "R1 ctrl reset", 16'h0);
    bus_read(DATA, "R1 data reset", 16'h0);
    phy_rd(1, 2, 3, "R1 phy word reset", 16'h0);

    bus_write(CTRL, 16'hFFFF);
    bus_read(CTRL, "R2 ctrl bit0 set", 16'h0001);
    bus_write(CTRL, 16'hFFFE);
    bus_read(CTRL, "R2 ctrl bit0 clear", 16'h0000);

    // R5 busy window
    bus_write(CTRL, 16'h0);
    bus_write(tadr(2, 3, 7), 16'hA5A5);
    #1; n = 0;
    while (busy === 1'b1) begin n++; @(negedge clk); #1; end
    chk("R5 busy length", 16'(n), 16'(BC));
    phy_rd(2, 3, 7, "R3 write then read", 16'hA5A5);

    // R6 data held during busy, R4 data of read launch ignored
    bus_write(CTRL, 16'h1);
    bus_write(tadr(0, 0, 0), 16'h7777);
    bus_read(DATA, "R6 old data during busy", 16'hA5A5);
    wait_idle();
    bus_read(DATA, "R4 read result", 16'h0000);
    phy_rd(0, 0, 0, "R4 read launch data ignored", 16'h0000);

    // R10 independence and corners
    phy_wr(3, 3, 7, 16'h5A5A);
    phy_wr(2, 4, 7, 16'h1111);
    phy_wr(4, 7, 31, 16'hFFFF);
    phy_wr(0, 0, 0, 16'h0001);
    phy_rd(2, 3, 7, "R10 neighbour intact", 16'hA5A5);
    phy_rd(3, 3, 7, "R10 other phy", 16'h5A5A);
    phy_rd(2, 4, 7, "R10 other page", 16'h1111);
    phy_rd(4, 7, 31, "R10 top corner", 16'hFFFF);
    phy_rd(0, 0, 0, "R10 bottom corner", 16'h0001);

    // R8 launch while busy ignored
    bus_write(CTRL, 16'h0);
    bus_write(tadr(1, 1, 1), 16'h2222);
    bus_write(tadr(1, 1, 2), 16'h3333);
    wait_idle();
    chk("R8 no err from busy launch", {15'b0, err}, 16'h0);
    phy_rd(1, 1, 2, "R8 second launch dropped", 16'h0000);
    phy_rd(1, 1, 1, "R8 first launch kept", 16'h2222);

    // R9 unmapped read
    bus_read(16'h0005, "R9 unmapped read", 16'h0);
    bus_read(16'h8004, "R9 unmapped high read", 16'h0);

    // R7 illegal launches
    bus_write(CTRL, 16'h0);
    bus_write(16'h8000 | 16'(5 << 5) | 16'd1, 16'h4444);
    #1;
    chk("R7 no select err", {15'b0, err}, 16'h1);
    chk("R7 no select no busy", {15'b0, busy}, 16'h0);
    bus_write(16'h8000 | 16'(3 << 9) | 16'd4, 16'h4444);
    bus_write(16'h8000 | 16'(1 << 9) | 16'(8 << 5) | 16'd4, 16'h4444);
    #1;
    chk("R7 page 8 no busy", {15'b0, busy}, 16'h0);
    phy_rd(0, 0, 4, "R7 multi select no write", 16'h0000);
    phy_rd(1, 0, 4, "R7 page 8 no alias write", 16'h0000);
    #1;
    chk("R7 err sticky", {15'b0, err}, 16'h1);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule